// File: doc/BRIEF.md
# Multi-Hart Machine Timer Unit

This block holds one 64-bit real-time counter that a group of harts share, plus one 64-bit compare register for each hart. Each hart has its own level-sensitive timer interrupt. The counter advances by one on every clock where the tick enable is high. Each interrupt stays asserted for as long as that hart's compare value is not above the current time.

Software reaches the counter and the compare registers through a simple register strobe interface. Every register can be accessed as a whole 64-bit value or as two 32-bit halves. Because the comparison runs continuously, a write to any compare register takes effect at once. A write to the counter does the same and re-evaluates every hart's interrupt. Hardware integrators set the number of harts and the two base addresses through parameters. The hart count can go up to 16.

Top module: `mtimer_unit`

## Requirements
- R1: During and after reset the time counter reads 0, every compare register reads all ones (0xFFFF_FFFF_FFFF_FFFF), every timer interrupt is low and read data is 0.
- R2: The time counter rises by one on each clock with `tick_en` high and holds otherwise; it wraps from all ones to zero.
- R3: `timer_irq[i]` is high exactly when compare register i is less than or equal to the time counter (unsigned), and follows any write to either with no extra delay.
- R4: Compare register i lives at `CMP_BASE + 8*i`. A 4-byte access at +0 reaches bits 31:0 and one at +4 reaches bits 63:32; an 8-byte access at +0 reaches all 64 bits. A 4-byte write changes only its own half.
- R5: The time counter lives at `TIME_BASE` with the same half/whole layout as R4. A write to it in the same cycle as a tick takes the written value, with no increment.
- R6: A valid read returns its data on `bus_rdata` one cycle after the request. A 4-byte read places the word in bits 31:0 with bits 63:32 zero. In any cycle after a non-read, `bus_rdata` is zero.
- R7: The size codes are 2'b10 for 4 bytes and 2'b11 for 8 bytes. Any of the following requests is invalid: another size code, an address with bits 1:0 not zero, an 8-byte access at offset +4, or a compare address beyond the last hart or any other unmapped address. An invalid write changes nothing, and an invalid read returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timebase tick; advances the counter |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | 2'b10 = 4 bytes, 2'b11 = 8 bytes |
| bus_wdata | input | 64 | Write data; 4-byte writes use bits 31:0 |
| bus_rdata | output | 64 | Read data, one cycle after the request |
| timer_irq | output | NUM_HARTS | Per-hart level timer interrupt |

## Verification
A corrupted compare register or counter shows at the ports without delay, because the interrupt of the hart concerned takes the wrong level in the cycle after the bad update. A fault in the half-merge shows only at a later read or at a later time crossing, so the bench reads each register back after every half write. The bench also runs the counter across the point where a compare value is crossed, so that a bad upper word becomes visible. Faults in decode show on the first access to a hart beyond the last one, a misaligned address, or an 8-byte access at +4. In each of these cases a register the bench can read back changes, or the read data is not zero.

// File: rtl/mtu_pkg.sv
package mtu_pkg;
  typedef enum logic [1:0] {
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } acc_size_e;

  localparam int MAX_HARTS = 16;

  // Merge write data into an existing 64-bit register value.
  function automatic logic [63:0] fold_write(input logic [63:0] old_val,
                                             input logic [63:0] wdata,
                                             input logic        upper,
                                             input logic        full);
    if (full)       return wdata;
    else if (upper) return {wdata[31:0], old_val[31:0]};
    else            return {old_val[63:32], wdata[31:0]};
  endfunction

  // Select the part of a register a read returns.
  function automatic logic [63:0] read_view(input logic [63:0] val,
                                            input logic        upper,
                                            input logic        full);
    if (full)       return val;
    else if (upper) return {32'h0, val[63:32]};
    else            return {32'h0, val[31:0]};
  endfunction
endpackage

// File: rtl/mtu_decode.sv
module mtu_decode
  import mtu_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          NUM_HARTS = 4,
  parameter int          HW        = 2,
  parameter logic [15:0] CMP_BASE  = 16'h0000,
  parameter logic [15:0] TIME_BASE = 16'h0100
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              acc_ok,
  output logic              hit_time,
  output logic              hit_cmp,
  output logic [HW-1:0]     hart,
  output logic              upper,
  output logic              full
);
  localparam logic [ADDR_W-1:0] CMP_B   = ADDR_W'(CMP_BASE);
  localparam logic [ADDR_W-1:0] TIME_B  = ADDR_W'(TIME_BASE);
  localparam logic [ADDR_W-1:0] CMP_SPN = ADDR_W'(8 * NUM_HARTS);

  logic [ADDR_W-1:0] cmp_off;
  logic              size_ok, align_ok, wide_hi, in_cmp, in_time;

  always_comb begin
    cmp_off  = addr - CMP_B;
    size_ok  = (size == SZ_WORD) || (size == SZ_DWORD);
    align_ok = (addr[1:0] == 2'b00);
    wide_hi  = (size == SZ_DWORD) && addr[2];
    in_cmp   = (addr >= CMP_B) && (cmp_off < CMP_SPN);
    in_time  = (addr[ADDR_W-1:3] == TIME_B[ADDR_W-1:3]);
    acc_ok   = size_ok && align_ok && !wide_hi && (in_cmp || in_time);
    hit_time = acc_ok && in_time;
    hit_cmp  = acc_ok && in_cmp && !in_time;
    hart     = cmp_off[3 +: HW];
    upper    = addr[2];
    full     = (size == SZ_DWORD);
  end
endmodule

// File: rtl/mtu_time_counter.sv
module mtu_time_counter (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic [63:0] wr_val,
  output logic [63:0] time_q
);
  always_ff @(posedge clk) begin
    if (rst)          time_q <= 64'h0;
    else if (wr_en)   time_q <= wr_val;
    else if (tick_en) time_q <= time_q + 64'd1;
  end
endmodule

// File: rtl/mtu_cmp_bank.sv
module mtu_cmp_bank
  import mtu_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int HW        = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [HW-1:0]              wr_hart,
  input  logic                       upper,
  input  logic                       full,
  input  logic [63:0]                wdata,
  input  logic [63:0]                time_q,
  output logic [NUM_HARTS-1:0][63:0] cmp_vals,
  output logic [NUM_HARTS-1:0]       cmp_we,
  output logic [NUM_HARTS-1:0]       irq
);
  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_hart
    assign cmp_we[i] = wr_en && (wr_hart == HW'(i));

    always_ff @(posedge clk) begin
      if (rst)            cmp_vals[i] <= '1;
      else if (cmp_we[i]) cmp_vals[i] <= fold_write(cmp_vals[i], wdata, upper, full);
    end

    assign irq[i] = (cmp_vals[i] <= time_q);
  end
endmodule

// File: rtl/mtimer_unit.sv
module mtimer_unit
  import mtu_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          NUM_HARTS = 4,
  parameter logic [15:0] CMP_BASE  = 16'h0000,
  parameter logic [15:0] TIME_BASE = 16'h0100
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_en,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [1:0]           bus_size,
  input  logic [63:0]          bus_wdata,
  output logic [63:0]          bus_rdata,
  output logic [NUM_HARTS-1:0] timer_irq
);
  localparam int HW = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  logic                       acc_ok, hit_time, hit_cmp, upper, full;
  logic [HW-1:0]              hart;
  logic                       time_we, cmp_wr, rd_ok;
  logic [63:0]                time_q, time_nxt, rd_src;
  logic [NUM_HARTS-1:0][63:0] cmp_vals;
  logic [NUM_HARTS-1:0]       cmp_we;

  mtu_decode #(
    .ADDR_W(ADDR_W), .NUM_HARTS(NUM_HARTS), .HW(HW),
    .CMP_BASE(CMP_BASE), .TIME_BASE(TIME_BASE)
  ) u_dec (
    .addr(bus_addr), .size(bus_size), .acc_ok(acc_ok), .hit_time(hit_time),
    .hit_cmp(hit_cmp), .hart(hart), .upper(upper), .full(full)
  );

  assign time_we  = bus_valid && bus_write && hit_time;
  assign cmp_wr   = bus_valid && bus_write && hit_cmp;
  assign rd_ok    = bus_valid && !bus_write && acc_ok;
  assign time_nxt = fold_write(time_q, bus_wdata, upper, full);

  mtu_time_counter u_time (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .wr_en(time_we), .wr_val(time_nxt), .time_q(time_q)
  );

  mtu_cmp_bank #(.NUM_HARTS(NUM_HARTS), .HW(HW)) u_cmp (
    .clk(clk), .rst(rst), .wr_en(cmp_wr), .wr_hart(hart), .upper(upper),
    .full(full), .wdata(bus_wdata), .time_q(time_q),
    .cmp_vals(cmp_vals), .cmp_we(cmp_we), .irq(timer_irq)
  );

  assign rd_src = hit_time ? time_q : cmp_vals[hart];

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= 64'h0;
    else if (rd_ok) bus_rdata <= read_view(rd_src, upper, full);
    else            bus_rdata <= 64'h0;
  end
endmodule

// File: rtl/mtu_checker.sv
module mtu_checker #(
  parameter int NUM_HARTS = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       tick_en,
  input logic                       bus_valid,
  input logic                       bus_write,
  input logic [63:0]                bus_rdata,
  input logic [NUM_HARTS-1:0]       timer_irq,
  input logic [63:0]                time_q,
  input logic [NUM_HARTS-1:0][63:0] cmp_vals,
  input logic                       time_we,
  input logic [NUM_HARTS-1:0]       cmp_we
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (time_q == 64'h0) && (bus_rdata == 64'h0) && (timer_irq == '0));

  p_tick_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !time_we) |=> time_q == $past(time_q) + 64'd1);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !time_we) |=> $stable(time_q));

  p_idle_rdata_r6: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> bus_rdata == 64'h0);

  p_one_target_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({time_we, cmp_we}));

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_chk
    p_cmp_keep_r4: assert property (@(posedge clk) disable iff (rst)
      !cmp_we[i] |=> $stable(cmp_vals[i]));

    p_irq_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      (!cmp_we[i] && !time_we && !tick_en) |=> $stable(timer_irq[i]));
  end
endmodule

bind mtimer_unit mtu_checker #(.NUM_HARTS(NUM_HARTS)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .bus_valid(bus_valid),
  .bus_write(bus_write), .bus_rdata(bus_rdata), .timer_irq(timer_irq),
  .time_q(time_q), .cmp_vals(cmp_vals), .time_we(time_we), .cmp_we(cmp_we)
);

// File: tb/tb_mtimer_unit.sv
module tb_mtimer_unit;
  localparam int          N  = 4;
  localparam logic [15:0] TB = 16'h0100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0, bus_valid = 1'b0, bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [1:0]  bus_size = 2'b10;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [N-1:0] timer_irq;

  int checks = 0, fails = 0;
  bit done = 0;

  longint unsigned m_time;
  longint unsigned m_cmp[N];
  longint unsigned m_rd;

  always #4 clk = ~clk;

  mtimer_unit #(.ADDR_W(16), .NUM_HARTS(N), .CMP_BASE(16'h0000), .TIME_BASE(TB)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_irq(timer_irq)
  );

  task automatic check(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic longint unsigned merge(longint unsigned old, longint unsigned wd,
                                            bit hi, bit wide);
    longint unsigned lo_mask = 64'h0000_0000_FFFF_FFFF;
    if (wide) return wd;
    if (hi)   return (old & lo_mask) | ((wd & lo_mask) << 32);
    return (old & ~lo_mask) | (wd & lo_mask);
  endfunction

  function automatic logic [N-1:0] exp_irq();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (m_cmp[i] <= m_time);
    return v;
  endfunction

  // One clock with the given request; model advanced and compared each clock.
  task automatic step(bit v, bit w, logic [15:0] a, logic [1:0] sz,
                      longint unsigned wd, bit tk);
    bit ok, is_t, is_c, hi, wide;
    int idx;
    longint unsigned nt, nr, src;
    longint unsigned nc[N];
    bus_valid = v; bus_write = w; bus_addr = a; bus_size = sz;
    bus_wdata = wd; tick_en = tk;
    wide = (sz == 2'b11);
    hi   = a[2];
    is_t = (a[15:3] == TB[15:3]);
    is_c = (int'(a) < 8 * N) && !is_t;
    idx  = int'(a) / 8;
    ok   = v && (sz == 2'b10 || sz == 2'b11) && (a[1:0] == 2'b00)
           && !(wide && hi) && (is_t || is_c);
    nt = tk ? m_time + 1 : m_time;
    for (int i = 0; i < N; i++) nc[i] = m_cmp[i];
    nr = 0;
    if (ok && w && is_t) nt = merge(m_time, wd, hi, wide);
    if (ok && w && is_c) nc[idx] = merge(m_cmp[idx], wd, hi, wide);
    if (ok && !w) begin
      src = is_t ? m_time : m_cmp[idx];
      nr = wide ? src : (hi ? (src >> 32) : (src & 64'hFFFF_FFFF));
    end
    @(posedge clk);
    @(negedge clk);
    m_time = nt; m_rd = nr;
    for (int i = 0; i < N; i++) m_cmp[i] = nc[i];
    check("R3 irq vs model", longint'(timer_irq), longint'(exp_irq()));
    check("R6 rdata vs model", bus_rdata, m_rd);
    bus_valid = 0; tick_en = 0;
  endtask

  task automatic idle(int n, bit tk);
    for (int k = 0; k < n; k++) step(0, 0, 16'h0, 2'b10, 0, tk);
  endtask

  task automatic rd(string tag, logic [15:0] a, logic [1:0] sz, longint unsigned exp);
    step(1, 0, a, sz, 0, 0);
    check(tag, bus_rdata, exp);
  endtask

  task automatic wr(logic [15:0] a, logic [1:0] sz, longint unsigned d, bit tk);
    step(1, 1, a, sz, d, tk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_time = 0; m_rd = 0;
    for (int i = 0; i < N; i++) m_cmp[i] = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset irq", longint'(timer_irq), 0);
    check("R1 reset rdata", bus_rdata, 0);
    rst = 0;
    rd("R1 time after reset", TB, 2'b11, 0);
    rd("R1 cmp2 after reset", 16'h0010, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF);

    idle(5, 1);
    rd("R2 time after 5 ticks", TB, 2'b11, 5);
    idle(2, 0);
    rd("R2 time holds without tick", TB, 2'b11, 5);

    wr(16'h0000, 2'b10, 64'hAAAA_AAAA_0000_0003, 0);
    rd("R4 low half write keeps high", 16'h0000, 2'b11, 64'hFFFF_FFFF_0000_0003);
    rd("R6 4-byte read of high half", 16'h0004, 2'b10, 64'h0000_0000_FFFF_FFFF);
    check("R3 irq0 low while cmp above time", longint'(timer_irq), 0);
    wr(16'h0004, 2'b10, 64'h0, 0);
    check("R3 irq0 rises at once", longint'(timer_irq), 1);

    wr(16'h0008, 2'b11, 64'd8, 0);
    check("R3 irq1 low before time catches up", longint'(timer_irq), 1);
    idle(3, 1);
    check("R3 irq1 rises when time reaches cmp", longint'(timer_irq), 3);
    rd("R4 4-byte read of cmp1 low", 16'h0008, 2'b10, 8);

    wr(TB, 2'b11, 64'h0, 0);
    check("R5 time rewrite drops irqs", longint'(timer_irq), 0);
    wr(TB + 16'h4, 2'b10, 64'h1, 1);
    rd("R5 write wins over tick", TB, 2'b11, 64'h0000_0001_0000_0000);
    check("R3 irqs after time jump", longint'(timer_irq), 3);
    rd("R6 4-byte time high read", TB + 16'h4, 2'b10, 1);

    wr(16'h0014, 2'b11, 64'h0, 0);
    rd("R7 8-byte write at +4 ignored", 16'h0010, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R7 8-byte read at +4 is zero", TB + 16'h4, 2'b11, 0);
    wr(TB, 2'b01, 64'h55, 0);
    rd("R7 bad size write ignored", TB, 2'b11, 64'h0000_0001_0000_0000);
    rd("R7 bad size read is zero", TB, 2'b00, 0);
    wr(16'h0002, 2'b10, 64'h0, 0);
    rd("R7 misaligned write ignored", 16'h0000, 2'b11, 3);
    rd("R7 misaligned read is zero", TB + 16'h2, 2'b10, 0);
    wr(16'h0020, 2'b11, 64'h0, 0);
    rd("R7 beyond last hart reads zero", 16'h0020, 2'b11, 0);
    check("R7 beyond last hart leaves irqs", longint'(timer_irq), 3);
    rd("R7 unmapped read is zero", 16'h0200, 2'b10, 0);

    wr(TB, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    check("R3 equal compare asserts", longint'(timer_irq), 4'hF);
    idle(1, 1);
    rd("R2 counter wraps to zero", TB, 2'b11, 0);
    check("R3 irqs after wrap", longint'(timer_irq), 0);

    wr(16'h0018, 2'b11, 64'd2, 0);
    idle(2, 1);
    check("R3 hart3 fires at time 2", longint'(timer_irq), 4'h8);

    rst = 1;
    @(posedge clk); @(negedge clk);
    rst = 0;
    m_time = 0; m_rd = 0;
    for (int i = 0; i < N; i++) m_cmp[i] = 64'hFFFF_FFFF_FFFF_FFFF;
    check("R1 reset clears irqs", longint'(timer_irq), 0);
    rd("R1 reset restores cmp3", 16'h0018, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule